// File: doc/BRIEF.md
# Bidirectional Reset Pin Controller

This block merges every reset source of the chip into one internal reset and runs a shared active-low, open-drain reset pin in both directions. A low level on the pin from outside resets the chip. An internal failure, either an enabled watchdog timeout or an enabled clock-monitor alarm, makes the block pull the pin low so that the rest of the board also sees the failure.

The internal reset goes low asynchronously, so it still works when the clock has died. It is released only through a chain of synchronizer flops, so it always leaves reset on a clock edge. After an internal failure the pin is pulled low for a fixed number of clock cycles and then let go. A fixed number of cycles after that, the block samples the pin. A pin that is still low then shows that something outside is holding it, and the cause register records an external reset. A 2-bit cause register tells the four sources apart. Power-on clears it.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is low, `pin_drive` is low and `cause` reads 0 (power-on). No clock edge is needed for any of this.
- R2: When `wdog_trip` and `wdog_en` are both high at a rising edge while the block is idle, `pin_drive` goes high after that edge. It stays high for exactly DRIVE_CYC cycles (16 by default), and `cause` reads 1 (watchdog).
- R3: While `cmon_fail` and `cmon_en` are both high, `pin_drive` is high and `sys_rst_n` is low even if no clock edge occurs. A sampled alarm starts the same DRIVE_CYC-cycle pull-down and sets `cause` to 2 (clock monitor).
- R4: A watchdog trip with `wdog_en` low, or a clock-monitor alarm with `cmon_en` low, has no effect on `pin_drive`, `sys_rst_n` or `cause`.
- R5: A low `pin_in` while the block is idle pulls `sys_rst_n` low at once, leaves `pin_drive` low, and sets `cause` to 3 (external) at the next rising edge.
- R6: After the pull-down ends, the block samples `pin_in` on the WAIT_CYC-th rising edge (9 by default). If the pin is low there, `cause` becomes 3. If it is high, the internal cause is kept.
- R7: `sys_rst_n` rises on the SYNC_STAGES-th rising edge (2 by default) after every source has cleared: power-on released, no enabled alarm, the pull-down and pin check finished, and the pin high.
- R8: A watchdog trip that arrives during the pull-down or the pin check does not restart the pull-down.
- R9: When an enabled watchdog trip and an enabled clock-monitor alarm are sampled on the same edge, `cause` records the clock monitor (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdog_trip | input | 1 | Watchdog timeout event |
| wdog_en | input | 1 | Watchdog reset enable |
| cmon_fail | input | 1 | Clock monitor slow/stopped clock alarm |
| cmon_en | input | 1 | Clock monitor reset enable |
| pin_in | input | 1 | Sampled level of the reset pin (1 = high) |
| pin_drive | output | 1 | Open-drain pull-down enable for the reset pin |
| sys_rst_n | output | 1 | Internal reset, active low |
| cause | output | 2 | Reset cause: 0 power-on, 1 watchdog, 2 clock monitor, 3 external |

## Verification
The bench builds the block with its defaults: a 16-cycle pull-down, a 9-cycle pin check and a 2-stage synchronizer. With these values a sweep of the external pin rise delay from 0 to 12 cycles after the drive is released is short. The sweep covers both sides of the 9-cycle check edge and both release timings of the synchronizer, and it runs for the watchdog, for the clock monitor and for the two together. The clock is also stopped outright to show that a clock-monitor alarm reaches the pin and the internal reset without any edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_WDOG = 2'd1,
        CAUSE_CMON = 2'd2,
        CAUSE_EXT  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/rstc_combine.sv
module rstc_combine (
    input  logic por_n,
    input  logic wdog_trip,
    input  logic wdog_en,
    input  logic cmon_fail,
    input  logic cmon_en,
    input  logic pin_in,
    input  logic seq_busy,
    output logic wdog_hit,
    output logic cmon_hit,
    output logic arst_n
);
    always_comb begin
        wdog_hit = wdog_trip & wdog_en;
        cmon_hit = cmon_fail & cmon_en;
        // Any source pulls the internal reset low without a clock edge.
        arst_n   = por_n & ~cmon_hit & pin_in & ~seq_busy;
    end
endmodule

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], 1'b1};
    end

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg_q[i] <= 1'b0;
                else         stg_q[i] <= stg_d[i];
            end
        end
    endgenerate

    assign rst_n_o = stg_q[STAGES-1];
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int DRIVE_CYC = 16,
    parameter int WAIT_CYC  = 9
) (
    input  logic   clk,
    input  logic   por_n,
    input  logic   wdog_hit,
    input  logic   cmon_hit,
    input  logic   pin_in,
    output logic   drive,
    output logic   busy,
    output cause_e cause
);
    localparam int CNT_MAX = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
    localparam int CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CW-1:0] DRIVE_LAST = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_CYC - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        cause_e        cause;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmon_hit) begin
                    r_d.st    = ST_DRIVE;
                    r_d.cnt   = '0;
                    r_d.cause = CAUSE_CMON;
                end else if (wdog_hit) begin
                    r_d.st    = ST_DRIVE;
                    r_d.cnt   = '0;
                    r_d.cause = CAUSE_WDOG;
                end else if (!pin_in) begin
                    r_d.cause = CAUSE_EXT;
                end
            end
            ST_DRIVE: begin
                if (r_q.cnt == DRIVE_LAST) begin
                    r_d.st  = ST_WAIT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (r_q.cnt == WAIT_LAST) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                    if (!pin_in) r_d.cause = CAUSE_EXT;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '{st: ST_IDLE, cnt: '0, cause: CAUSE_POR};
        else        r_q <= r_d;
    end

    assign drive = (r_q.st == ST_DRIVE);
    assign busy  = (r_q.st != ST_IDLE);
    assign cause = r_q.cause;

    // R2: a pull-down only begins with an internal failure recorded
    a_r2_drive_has_cause: assert property (@(posedge clk) disable iff (!por_n)
        $rose(drive) |-> (cause == CAUSE_WDOG || cause == CAUSE_CMON));

    // R8: the pin check never falls back into the pull-down
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.st == ST_WAIT) |=> (r_q.st != ST_DRIVE));

    // R6: the check ends in idle, never straight in another phase
    a_r6_wait_exits_idle: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.st == ST_WAIT && r_q.cnt == WAIT_LAST) |=> (r_q.st == ST_IDLE));
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
    import rstc_pkg::*;
#(
    parameter int DRIVE_CYC   = 16,
    parameter int WAIT_CYC    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wdog_trip,
    input  logic       wdog_en,
    input  logic       cmon_fail,
    input  logic       cmon_en,
    input  logic       pin_in,
    output logic       pin_drive,
    output logic       sys_rst_n,
    output logic [1:0] cause
);
    logic   wdog_hit;
    logic   cmon_hit;
    logic   arst_n;
    logic   seq_drive;
    logic   seq_busy;
    cause_e seq_cause;

    rstc_combine u_combine (
        .por_n    (por_n),
        .wdog_trip(wdog_trip),
        .wdog_en  (wdog_en),
        .cmon_fail(cmon_fail),
        .cmon_en  (cmon_en),
        .pin_in   (pin_in),
        .seq_busy (seq_busy),
        .wdog_hit (wdog_hit),
        .cmon_hit (cmon_hit),
        .arst_n   (arst_n)
    );

    rstc_seq #(
        .DRIVE_CYC(DRIVE_CYC),
        .WAIT_CYC (WAIT_CYC)
    ) u_seq (
        .clk     (clk),
        .por_n   (por_n),
        .wdog_hit(wdog_hit),
        .cmon_hit(cmon_hit),
        .pin_in  (pin_in),
        .drive   (seq_drive),
        .busy    (seq_busy),
        .cause   (seq_cause)
    );

    rstc_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .rst_n_o(sys_rst_n)
    );

    // The alarm path reaches the pin with no clock dependency.
    assign pin_drive = seq_drive | cmon_hit;
    assign cause     = seq_cause;

    // R3: an enabled alarm holds both the pin and the internal reset
    a_r3_cmon_async: assert property (@(posedge clk) disable iff (!por_n)
        cmon_hit |-> (pin_drive && !sys_rst_n));

    // R7: reset leaves only after the sources were clear on the edge before
    a_r7_release_after_clear: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> $past(arst_n));

    // R2: the internal reset is held for the whole sequence
    a_r2_busy_holds_reset: assert property (@(posedge clk) disable iff (!por_n)
        seq_busy |-> !sys_rst_n);

    // R4: with both enables low nothing starts a pull-down
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (!wdog_en && !cmon_en && !seq_busy) |=> !pin_drive);
endmodule

// File: tb/rstpin_ctrl_tb_top.sv
module rstpin_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DRV        = 16;
    localparam int WT         = 9;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic por_n = 1'b0;
    logic wdog_trip = 1'b0, wdog_en = 1'b1;
    logic cmon_fail = 1'b0, cmon_en = 1'b1;
    logic hold_low = 1'b0;
    logic pin_in;
    logic pin_drive, sys_rst_n;
    logic [1:0] cause;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    assign pin_in = ~(pin_drive | hold_low);

    always #(CLK_PERIOD/2) if (clk_run) clk = ~clk;
    always @(posedge clk) cyc++;

    rstpin_ctrl dut_i (
        .clk(clk), .por_n(por_n), .wdog_trip(wdog_trip), .wdog_en(wdog_en),
        .cmon_fail(cmon_fail), .cmon_en(cmon_en), .pin_in(pin_in),
        .pin_drive(pin_drive), .sys_rst_n(sys_rst_n), .cause(cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0;
        #1;
        chk(sys_rst_n == 1'b0, "R1 rst", int'(sys_rst_n), 0);
        chk(pin_drive == 1'b0, "R1 drive", int'(pin_drive), 0);
        chk(cause == 2'd0, "R1 cause", int'(cause), 0);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk(sys_rst_n == 1'b0, "R7 por first edge", int'(sys_rst_n), 0);
        @(negedge clk);
        chk(sys_rst_n == 1'b1, "R7 por release", int'(sys_rst_n), 1);
    endtask

    // kind 0 watchdog, 1 clock monitor, 2 both; d = pin rise delay
    task automatic run_seq(input int kind, input int d, input bit poke);
        int exp_int;
        int rel;
        exp_int = (kind == 0) ? 1 : 2;
        rel = (d <= WT - 1) ? DRV + WT + 2 : DRV + d + 2;
        @(negedge clk);
        hold_low = 1'b1;
        if (kind != 1) wdog_trip = 1'b1;
        if (kind != 0) cmon_fail = 1'b1;
        #1;
        if (kind != 0) begin
            chk(pin_drive == 1'b1, "R3 drive before edge", int'(pin_drive), 1);
            chk(sys_rst_n == 1'b0, "R3 rst before edge", int'(sys_rst_n), 0);
        end
        for (int n = 0; n <= rel + 1; n++) begin
            @(negedge clk);
            if (n == 0) begin
                wdog_trip = 1'b0;
                cmon_fail = 1'b0;
                if (kind == 2) chk(int'(cause) == 2, "R9 both", int'(cause), 2);
                else chk(int'(cause) == exp_int, "R2/R3 cause", int'(cause), exp_int);
            end
            if (poke && n == DRV + 4) wdog_trip = 1'b1;
            if (poke && n == DRV + 5) wdog_trip = 1'b0;
            if (n == DRV + d) hold_low = 1'b0;
            chk(pin_drive == (n < DRV), "R2 drive window / R8", int'(pin_drive), int'(n < DRV));
            chk(sys_rst_n == (n >= rel), "R7 release", int'(sys_rst_n), int'(n >= rel));
            if (n == DRV + WT) begin
                if (d <= WT - 1) chk(int'(cause) == exp_int, "R6 pin high", int'(cause), exp_int);
                else chk(int'(cause) == 3, "R6 pin low", int'(cause), 3);
            end
        end
    endtask

    initial begin : watchdog
        wait (cyc >= WD_LIMIT);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int c0;
        #3;
        chk(sys_rst_n == 1'b0, "R1 rst at start", int'(sys_rst_n), 0);
        chk(pin_drive == 1'b0, "R1 drive at start", int'(pin_drive), 0);
        repeat (3) @(negedge clk);
        chk(cause == 2'd0, "R1 cause at start", int'(cause), 0);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R7 initial release", int'(sys_rst_n), 1);

        for (int k = 0; k < 3; k++)
            for (int d = 0; d <= 12; d++)
                run_seq(k, d, (k == 0 && (d == 3 || d == 10)));

        // R1: power-on clears the recorded cause
        do_por();

        // R4: disabled watchdog then disabled clock monitor
        for (int k = 0; k < 2; k++) begin
            c0 = int'(cause);
            @(negedge clk);
            if (k == 0) begin wdog_en = 1'b0; wdog_trip = 1'b1; end
            else begin cmon_en = 1'b0; cmon_fail = 1'b1; end
            for (int n = 0; n < 30; n++) begin
                @(negedge clk);
                chk(pin_drive == 1'b0, "R4 drive", int'(pin_drive), 0);
                chk(sys_rst_n == 1'b1, "R4 rst", int'(sys_rst_n), 1);
                chk(int'(cause) == c0, "R4 cause", int'(cause), c0);
            end
            wdog_trip = 1'b0; cmon_fail = 1'b0;
            @(negedge clk);
            wdog_en = 1'b1; cmon_en = 1'b1;
        end

        // R5: external pin low for several lengths
        for (int len = 1; len <= 5; len++) begin
            @(negedge clk);
            hold_low = 1'b1;
            #1;
            chk(sys_rst_n == 1'b0, "R5 rst immediate", int'(sys_rst_n), 0);
            for (int n = 0; n < len; n++) begin
                @(negedge clk);
                chk(pin_drive == 1'b0, "R5 no drive", int'(pin_drive), 0);
                chk(int'(cause) == 3, "R5 cause", int'(cause), 3);
            end
            hold_low = 1'b0;
            @(negedge clk);
            chk(sys_rst_n == 1'b0, "R7 ext first edge", int'(sys_rst_n), 0);
            @(negedge clk);
            chk(sys_rst_n == 1'b1, "R7 ext release", int'(sys_rst_n), 1);
            do_por();
        end

        // R3: alarm with the clock stopped
        @(negedge clk);
        clk_run = 1'b0;
        #(CLK_PERIOD * 3);
        cmon_fail = 1'b1;
        #1;
        chk(pin_drive == 1'b1, "R3 stopped clk drive", int'(pin_drive), 1);
        chk(sys_rst_n == 1'b0, "R3 stopped clk rst", int'(sys_rst_n), 0);
        #(CLK_PERIOD * 2);
        clk_run = 1'b1;
        @(negedge clk);
        cmon_fail = 1'b0;
        chk(int'(cause) == 2, "R3 stopped clk cause", int'(cause), 2);
        repeat (DRV + WT + 4) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R7 after stopped clk", int'(sys_rst_n), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule